// File: doc/BRIEF.md
# SIMD Lane-wise Sign-Run Counter

This unit takes one packed vector per transfer and treats it as a row of signed lanes. For every lane it reports how many bits, going down from just below the lane's top bit, repeat the value of that top bit. The top bit itself is never counted, and the count ends at the first bit that differs. Every lane is worked on at once. Each count is written, zero-extended, into the same lane position of the result vector.

A small decoder sits in front of the counters and reads raw instruction fields. A two-bit size code picks the lane width. A Q bit picks 128-bit or 64-bit operation. Two extension bits joined to two 4-bit fields give 5-bit destination and source register indices. Encodings that cannot be executed are flagged and produce no count data.

Transfers come in on a valid/ready handshake and leave from an output register with one cycle of latency. The output stage is a two-state machine:
- `ST_EMPTY` means no result is held.
- `ST_FULL` means a result is presented.

Its transitions are:
- `LOAD` (EMPTY to FULL): an input is accepted.
- `RELOAD` (FULL to FULL): the result is taken and a new input is accepted in the same cycle.
- `HOLD` (FULL to FULL): the consumer stalls.
- `DRAIN` (FULL to EMPTY): the result is taken and no input arrives.

Top module: `simd_sign_run_counter`

## Requirements
- R1: For each lane, the result equals the number of consecutive bits just below the lane's most significant bit that equal that bit. The most significant bit is excluded, and the count stops at the first differing bit.
- R2: A lane whose bits are all 0 or all 1 yields lane width minus one: 7, 15 or 31.
- R3: in_size selects the lane width: 2'b00 gives 8 bits, 2'b01 gives 16 bits and 2'b10 gives 32 bits. Lane k occupies bits [k*W +: W] in both in_vec and out_vec.
- R4: With in_q=1 all 128 bits are processed. With in_q=0 only bits [63:0] are processed and out_vec[127:64] is zero.
- R5: out_dst_idx equals {in_d, in_vd} and out_src_idx equals {in_m, in_vm} of the accepted input.
- R6: in_size=2'b11 sets out_bad=1 and forces out_vec to all zeros.
- R7: With in_q=1, an odd destination or source index (bit 0 of {in_d,in_vd} or of {in_m,in_vm} set) sets out_bad=1 and forces out_vec to all zeros.
- R8: An input accepted on a clock edge (in_valid and in_ready both high) appears with out_valid=1 right after that edge. out_valid is 0 after reset.
- R9: While out_valid=1 and out_ready=0, in_ready is 0 and all outputs hold their values.
- R10: in_ready is 1 whenever the output register is empty or out_ready=1, so one transfer per cycle is sustained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_vec | input | 128 | Source vector |
| in_size | input | 2 | Lane width code |
| in_q | input | 1 | 1 selects 128-bit operation, 0 selects 64-bit |
| in_d | input | 1 | Destination index extension bit |
| in_vd | input | 4 | Destination index low field |
| in_m | input | 1 | Source index extension bit |
| in_vm | input | 4 | Source index low field |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 128 | Per-lane counts |
| out_bad | output | 1 | Encoding was invalid |
| out_dst_idx | output | 5 | Decoded destination register index |
| out_src_idx | output | 5 | Decoded source register index |

## Verification
Random data almost never contains long runs of sign bits, so lanes whose count lands deep inside a 32-bit lane are rare from uniform stimulus. The bench builds such inputs by arithmetically shifting random words right by a random amount, which gives sign runs of every length in every lane width. Stalls that land while the next input is already waiting are the other hard case. The bench produces them by toggling out_ready and in_valid at random against a queue-based model that is compared on every cycle.

// File: rtl/ssrc_pkg.sv
package ssrc_pkg;
    localparam int IDX_W = 5;

    typedef enum logic [1:0] {
        LW_8   = 2'b00,
        LW_16  = 2'b01,
        LW_32  = 2'b10,
        LW_BAD = 2'b11
    } lane_w_e;

    typedef struct packed {
        logic             bad;
        lane_w_e          lw;
        logic             quad;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src;
    } dec_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ostate_e;
endpackage

// File: rtl/ssrc_decode.sv
module ssrc_decode
    import ssrc_pkg::*;
(
    input  logic [1:0] size_i,
    input  logic       q_i,
    input  logic       d_i,
    input  logic [3:0] vd_i,
    input  logic       m_i,
    input  logic [3:0] vm_i,
    output dec_t       dec_o
);
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src;
    logic             odd_pair;

    always_comb begin
        dst      = {d_i, vd_i};
        src      = {m_i, vm_i};
        odd_pair = q_i && (dst[0] || src[0]);
        dec_o.dst  = dst;
        dec_o.src  = src;
        dec_o.quad = q_i;
        dec_o.lw   = lane_w_e'(size_i);
        dec_o.bad  = (size_i == 2'b11) || odd_pair;
    end
endmodule

// File: rtl/ssrc_lane_count.sv
module ssrc_lane_count #(
    parameter int W = 8
) (
    input  logic [W-1:0] lane_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] c;
    logic         run;

    always_comb begin
        c   = '0;
        run = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            if (run && (lane_i[i] == lane_i[W-1])) begin
                c = c + 1'b1;
            end else begin
                run = 1'b0;
            end
        end
        cnt_o = c;
    end

    // R2: a uniform lane reaches the maximum count
    always_comb begin
        if (lane_i == '0 || lane_i == '1) begin
            p_uniform_max_r2: assert (cnt_o == W[W-1:0] - 1'b1);
        end
    end
endmodule

// File: rtl/ssrc_vec_count.sv
module ssrc_vec_count #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]      vec_i,
    output logic [2:0][VEC_W-1:0] res_o
);
    for (genvar gw = 0; gw < 3; gw++) begin : g_w
        localparam int LW = 8 << gw;
        localparam int NL = VEC_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_l
            ssrc_lane_count #(.W(LW)) u_lane (
                .lane_i (vec_i[l*LW +: LW]),
                .cnt_o  (res_o[gw][l*LW +: LW])
            );
        end
    end
endmodule

// File: rtl/simd_sign_run_counter.sv
module simd_sign_run_counter
    import ssrc_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] in_vec,
    input  logic [1:0]       in_size,
    input  logic             in_q,
    input  logic             in_d,
    input  logic [3:0]       in_vd,
    input  logic             in_m,
    input  logic [3:0]       in_vm,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_bad,
    output logic [IDX_W-1:0] out_dst_idx,
    output logic [IDX_W-1:0] out_src_idx
);
    localparam int HALF_W = VEC_W / 2;

    dec_t                  dec;
    logic [2:0][VEC_W-1:0] counts;
    logic [VEC_W-1:0]      sel_vec;
    logic [VEC_W-1:0]      nxt_vec;
    logic                  accept;
    ostate_e               state_q, state_d;

    ssrc_decode u_dec (
        .size_i (in_size),
        .q_i    (in_q),
        .d_i    (in_d),
        .vd_i   (in_vd),
        .m_i    (in_m),
        .vm_i   (in_vm),
        .dec_o  (dec)
    );

    ssrc_vec_count #(.VEC_W(VEC_W)) u_cnt (
        .vec_i (in_vec),
        .res_o (counts)
    );

    always_comb begin
        unique case (dec.lw)
            LW_8:    sel_vec = counts[0];
            LW_16:   sel_vec = counts[1];
            LW_32:   sel_vec = counts[2];
            default: sel_vec = '0;
        endcase
        if (dec.bad) begin
            nxt_vec = '0;
        end else if (!dec.quad) begin
            nxt_vec = {{HALF_W{1'b0}}, sel_vec[HALF_W-1:0]};
        end else begin
            nxt_vec = sel_vec;
        end
    end

    // output stage control
    assign in_ready = (state_q == ST_EMPTY) || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;                      // LOAD
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;     // DRAIN
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec     <= '0;
            out_bad     <= 1'b0;
            out_dst_idx <= '0;
            out_src_idx <= '0;
        end else if (accept) begin
            out_vec     <= nxt_vec;
            out_bad     <= dec.bad;
            out_dst_idx <= dec.dst;
            out_src_idx <= dec.src;
        end
    end

    assign out_valid = (state_q == ST_FULL);

    p_accept_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)
            && $stable(out_bad) && $stable(out_dst_idx) && $stable(out_src_idx)));

    p_bad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bad) |-> (out_vec == '0));

    p_size_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_size == 2'b11) |=> out_bad);

    p_half_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_q) |=> (out_vec[VEC_W-1:HALF_W] == '0));

    p_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_dst_idx == $past({in_d, in_vd})));
endmodule

// File: tb/test_simd_sign_run_counter.sv
module test_simd_sign_run_counter;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_vec = '0;
    logic [1:0]   in_size = '0;
    logic         in_q = 1'b0;
    logic         in_d = 1'b0;
    logic [3:0]   in_vd = '0;
    logic         in_m = 1'b0;
    logic [3:0]   in_vm = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_vec;
    logic         out_bad;
    logic [4:0]   out_dst_idx;
    logic [4:0]   out_src_idx;

    always #5 clk = ~clk;

    simd_sign_run_counter i_simd_sign_run_counter (
        .clk, .rst_n, .in_valid, .in_ready, .in_vec, .in_size, .in_q,
        .in_d, .in_vd, .in_m, .in_vm, .out_valid, .out_ready, .out_vec,
        .out_bad, .out_dst_idx, .out_src_idx
    );

    typedef struct {
        logic [127:0] vec;
        logic [1:0]   size;
        logic         q, d, m;
        logic [3:0]   vd, vm;
        string        tag;
    } item_t;

    typedef struct {
        logic [127:0] vec;
        logic         bad;
        logic [4:0]   dst, src;
        string        tag;
    } res_t;

    res_t expq[$];
    int   checks = 0;
    int   fails = 0;
    bit   done = 0;
    localparam int ND = 9;
    localparam int TOTAL = 600;

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic res_t model(item_t it);
        res_t r;
        int w, nl, cnt;
        bit run, top;
        r.dst = {it.d, it.vd};
        r.src = {it.m, it.vm};
        r.tag = it.tag;
        r.vec = '0;
        r.bad = 1'b0;
        if (it.size == 2'b11) begin
            r.bad = 1'b1; r.tag = "R6"; return r;
        end
        if (it.q && (r.dst[0] || r.src[0])) begin
            r.bad = 1'b1; r.tag = "R7"; return r;
        end
        w  = 8 << it.size;
        nl = (it.q ? 128 : 64) / w;
        for (int l = 0; l < nl; l++) begin
            top = it.vec[l*w + w - 1];
            cnt = 0;
            run = 1;
            for (int b = w - 2; b >= 0; b--) begin
                if (run && it.vec[l*w + b] == top) cnt++;
                else run = 0;
            end
            for (int b = 0; b < w; b++) r.vec[l*w + b] = ((cnt >> b) & 1) != 0;
        end
        return r;
    endfunction

    function automatic item_t mk(logic [127:0] v, logic [1:0] s, logic q,
                                 logic [4:0] di, logic [4:0] si, string tag);
        item_t it;
        it.vec = v; it.size = s; it.q = q;
        it.d = di[4]; it.vd = di[3:0]; it.m = si[4]; it.vm = si[3:0];
        it.tag = tag;
        return it;
    endfunction

    function automatic item_t directed(int k);
        case (k)
            0: return mk('0, 2'b00, 1'b1, 5'd2, 5'd4, "R2");
            1: return mk('1, 2'b01, 1'b1, 5'd6, 5'd8, "R2");
            2: return mk({4{32'h0000_00FF}}, 2'b10, 1'b1, 5'd10, 5'd12, "R1");
            3: return mk('1, 2'b00, 1'b0, 5'd3, 5'd7, "R4");
            4: return mk({16{8'h40}}, 2'b11, 1'b1, 5'd0, 5'd2, "R6");
            5: return mk({16{8'h40}}, 2'b00, 1'b1, 5'd1, 5'd2, "R7");
            6: return mk({16{8'h40}}, 2'b00, 1'b1, 5'd4, 5'd17, "R7");
            7: return mk(128'h80_40_C0_3F_01_FE_20_DF_7F_00_FF_81_10_E0_02_FC,
                        2'b00, 1'b1, 5'd30, 5'd20, "R1 R3");
            default: return mk(128'h8000_4000_C000_3FFF_0001_FFFE_0020_FFDF,
                               2'b01, 1'b0, 5'd31, 5'd19, "R3 R5");
        endcase
    endfunction

    function automatic item_t random_item();
        item_t it;
        logic [127:0] v;
        for (int j = 0; j < 4; j++) begin
            logic [31:0] wd;
            wd = $urandom;
            if ($urandom % 3 != 0) wd = 32'($signed(wd) >>> ($urandom % 32));
            v[j*32 +: 32] = wd;
        end
        it = mk(v, 2'($urandom % 4 == 3 ? ($urandom % 4) : ($urandom % 3)),
                1'($urandom), 5'($urandom), 5'($urandom), "R1 R3");
        if (!it.q) it.tag = "R4";
        return it;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        item_t cur;
        res_t  e;
        bit    have = 0;
        int    sent = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 reset out_valid", 128'(out_valid), 128'd0);
        chk(in_ready == 1'b1, "R10 reset in_ready", 128'(in_ready), 128'd1);
        rst_n = 1'b1;
        while (sent < TOTAL || expq.size() != 0) begin
            @(negedge clk);
            if (!have && sent < TOTAL) begin
                cur  = (sent < ND) ? directed(sent) : random_item();
                have = 1;
            end
            in_valid  = have && (sent < ND || ($urandom % 4) != 0);
            in_vec    = cur.vec;
            in_size   = cur.size;
            in_q      = cur.q;
            in_d      = cur.d;
            in_vd     = cur.vd;
            in_m      = cur.m;
            in_vm     = cur.vm;
            out_ready = (sent < ND) ? 1'b1 : (($urandom % 3) != 0);
            #1;
            chk(out_valid == (expq.size() != 0), "R8 out_valid",
                128'(out_valid), 128'(expq.size() != 0));
            chk(in_ready == (expq.size() == 0 || out_ready), "R9 R10 in_ready",
                128'(in_ready), 128'(expq.size() == 0 || out_ready));
            if (out_valid && expq.size() != 0) begin
                e = expq[0];
                chk(out_vec == e.vec, e.tag, out_vec, e.vec);
                chk(out_bad == e.bad, {e.tag, " out_bad"}, 128'(out_bad), 128'(e.bad));
                chk(out_dst_idx == e.dst, "R5 dst", 128'(out_dst_idx), 128'(e.dst));
                chk(out_src_idx == e.src, "R5 src", 128'(out_src_idx), 128'(e.src));
            end
            if (out_valid && out_ready && expq.size() != 0) void'(expq.pop_front());
            if (in_valid && in_ready) begin
                expq.push_back(model(cur));
                have = 0;
                sent++;
            end
        end
        in_valid = 1'b0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule